// File: doc/BRIEF.md
# Five-Input Prioritized Interrupt Controller

This block sits beside a small CPU core. It watches five interrupt request lines and, at each instruction boundary, picks one of them for service. One line cannot be masked. It is qualified by a rising edge that is still held high when the boundary arrives. A second line is caught by a rising-edge latch. Two further lines and a general request line act on their level.

The four maskable lines pass only while a global enable flip-flop is set. The instruction decoder sets that flip-flop with an enable strobe and clears it with a disable strobe. A three-bit per-line mask register can also block the three vectored maskable lines one at a time.

The chosen source and its fixed vector address are held until the CPU accepts the request with an acknowledge strobe. Acceptance clears the global enable. For the general request line the controller gives no address of its own. It drives an active-low acknowledge pulse instead, and the requesting device supplies the vector.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After a cycle with `rst` high, `int_en` is 0, `req_pend` is 0, `src` is 0, `vector` is 0, `vec_ext` is 0, `inta_n` is 1 and all three mask bits are 0.
- R2: Source codes on `src` are 0 none, 1 non-maskable, 2 edge line, 3 level line A, 4 level line B, 5 general line. When several lines qualify together, the lowest nonzero code wins.
- R3: `vector` is 0x0024 for code 1, 0x003C for code 2, 0x0034 for code 3, 0x002C for code 4, and 0x0000 for codes 0 and 5. `vec_ext` is 1 exactly when `src` is 5.
- R4: The non-maskable line qualifies at a boundary only if it has risen since it was last accepted and is still high at that boundary. It ignores `int_en` and the mask register. Holding it high after acceptance does not raise it again.
- R5: A rising edge on `irq_edge` is latched. The request survives the line falling again, and it is dropped only when that source is accepted or on reset.
- R6: The two level lines and the general line qualify only while high in the boundary cycle. A request that is sampled once and then dropped is withdrawn at the next boundary.
- R7: `dis_stb` clears `int_en` and `en_stb` sets it. If both are asserted in one cycle, `int_en` ends up 0. While `int_en` is 0, only the non-maskable line can be chosen.
- R8: An acknowledge while `req_pend` is 1 clears `req_pend`, `src` and `int_en` in the next cycle.
- R9: `src` changes only on the edge that ends a `boundary` cycle or an accepted acknowledge. An acknowledge while nothing is pending has no effect.
- R10: Accepting code 5 drives `inta_n` low for exactly the one cycle after the acknowledge cycle.
- R11: When `mask_wr` is high, `mask_in` loads the mask register. Bit 0 blocks the edge line, bit 1 blocks level line A and bit 2 blocks level line B. The general line has no mask bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_nmi | input | 1 | Non-maskable request |
| irq_edge | input | 1 | Rising-edge latched maskable request |
| irq_lvl_a | input | 1 | Level maskable request A |
| irq_lvl_b | input | 1 | Level maskable request B |
| irq_gen | input | 1 | General level request, externally vectored |
| en_stb | input | 1 | Set global enable |
| dis_stb | input | 1 | Clear global enable |
| mask_wr | input | 1 | Load mask register |
| mask_in | input | 3 | Mask bits: 0 edge, 1 level A, 2 level B |
| boundary | input | 1 | Instruction-boundary sample strobe |
| ack | input | 1 | CPU accepts the pending request |
| req_pend | output | 1 | A request is held for the CPU |
| src | output | 3 | Chosen source code |
| vector | output | 16 | Fixed service address of the chosen source |
| vec_ext | output | 1 | Vector must come from the device |
| inta_n | output | 1 | Active-low acknowledge for the general line |
| int_en | output | 1 | Global enable state |

## Verification
The assertions assume that all request lines and strobes are synchronous to `clk` and change only between edges. They also assume that `ack` is a one-cycle strobe from a CPU that raises it only in reply to a visible request. The bench drives every input at the falling edge and holds each strobe for a single cycle. It raises `ack` only after it has seen `req_pend`, except in the one case that checks an acknowledge with nothing pending is ignored. Each table row starts from reset, so the edge latches never carry state from one row into the next.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int VEC_W  = 16;
    localparam int MASK_W = 3;
    localparam int EDGE_N = 2;

    typedef enum logic [2:0] {
        SRC_NONE  = 3'd0,
        SRC_NMI   = 3'd1,
        SRC_EDGE  = 3'd2,
        SRC_LVL_A = 3'd3,
        SRC_LVL_B = 3'd4,
        SRC_GEN   = 3'd5
    } src_e;

    typedef struct packed {
        logic gen;
        logic lvl_b;
        logic lvl_a;
        logic edg;
        logic nmi;
    } lines_t;

    localparam logic [VEC_W-1:0] VEC_NMI   = 16'h0024;
    localparam logic [VEC_W-1:0] VEC_EDGE  = 16'h003C;
    localparam logic [VEC_W-1:0] VEC_LVL_A = 16'h0034;
    localparam logic [VEC_W-1:0] VEC_LVL_B = 16'h002C;

    function automatic logic [VEC_W-1:0] vec_of(src_e s);
        case (s)
            SRC_NMI:   return VEC_NMI;
            SRC_EDGE:  return VEC_EDGE;
            SRC_LVL_A: return VEC_LVL_A;
            SRC_LVL_B: return VEC_LVL_B;
            default:   return '0;
        endcase
    endfunction
endpackage

// File: rtl/irq_capture.sv
module irq_capture #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin,
    input  logic [N-1:0] clr,
    output logic [N-1:0] hit
);
    logic [N-1:0] prev_q;
    logic [N-1:0] lat_q;

    for (genvar i = 0; i < N; i++) begin : g_lat
        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q[i] <= 1'b0;
                lat_q[i]  <= 1'b0;
            end else begin
                prev_q[i] <= pin[i];
                if (clr[i])
                    lat_q[i] <= 1'b0;
                else if (pin[i] && !prev_q[i])
                    lat_q[i] <= 1'b1;
            end
        end
    end

    assign hit = lat_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
(
    input  lines_t qual,
    output src_e   win
);
    always_comb begin
        if (qual.nmi)        win = SRC_NMI;
        else if (qual.edg)   win = SRC_EDGE;
        else if (qual.lvl_a) win = SRC_LVL_A;
        else if (qual.lvl_b) win = SRC_LVL_B;
        else if (qual.gen)   win = SRC_GEN;
        else                 win = SRC_NONE;
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_nmi,
    input  logic              irq_edge,
    input  logic              irq_lvl_a,
    input  logic              irq_lvl_b,
    input  logic              irq_gen,
    input  logic              en_stb,
    input  logic              dis_stb,
    input  logic              mask_wr,
    input  logic [MASK_W-1:0] mask_in,
    input  logic              boundary,
    input  logic              ack,
    output logic              req_pend,
    output logic [2:0]        src,
    output logic [VEC_W-1:0]  vector,
    output logic              vec_ext,
    output logic              inta_n,
    output logic              int_en
);
    src_e              src_q;
    src_e              win;
    logic              gie_q;
    logic [MASK_W-1:0] mask_q;
    logic              inta_q;
    logic              accept;
    logic [EDGE_N-1:0] edge_pin, edge_clr, edge_hit;
    lines_t            qual;

    assign accept   = ack && (src_q != SRC_NONE);
    assign edge_pin = {irq_edge, irq_nmi};
    assign edge_clr = {accept && (src_q == SRC_EDGE), accept && (src_q == SRC_NMI)};

    irq_capture #(.N(EDGE_N)) u_cap (
        .clk (clk),
        .rst (rst),
        .pin (edge_pin),
        .clr (edge_clr),
        .hit (edge_hit)
    );

    always_comb begin
        qual.nmi   = edge_hit[0] && irq_nmi;
        qual.edg   = edge_hit[1] && gie_q && !mask_q[0];
        qual.lvl_a = irq_lvl_a   && gie_q && !mask_q[1];
        qual.lvl_b = irq_lvl_b   && gie_q && !mask_q[2];
        qual.gen   = irq_gen     && gie_q;
    end

    irq_arbiter u_arb (
        .qual (qual),
        .win  (win)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= SRC_NONE;
            gie_q  <= 1'b0;
            mask_q <= '0;
            inta_q <= 1'b1;
        end else begin
            if (accept)
                src_q <= SRC_NONE;
            else if (boundary)
                src_q <= win;

            if (accept)       gie_q <= 1'b0;
            else if (dis_stb) gie_q <= 1'b0;
            else if (en_stb)  gie_q <= 1'b1;

            if (mask_wr)
                mask_q <= mask_in;

            inta_q <= !(accept && (src_q == SRC_GEN));
        end
    end

    assign req_pend = (src_q != SRC_NONE);
    assign src      = src_q;
    assign vector   = vec_of(src_q);
    assign vec_ext  = (src_q == SRC_GEN);
    assign inta_n   = inta_q;
    assign int_en   = gie_q;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
    import irq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             boundary,
    input logic             ack,
    input logic             req_pend,
    input logic [2:0]       src,
    input logic [VEC_W-1:0] vector,
    input logic             vec_ext,
    input logic             inta_n,
    input logic             int_en
);
    p_ack_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (ack && req_pend) |=> (!int_en && !req_pend));

    p_src_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!boundary && !ack) |=> $stable(src));

    p_masked_only_nmi_r7: assert property (@(posedge clk) disable iff (rst)
        (boundary && !ack && !int_en) |=> (src == 3'd0 || src == 3'd1));

    p_inta_cause_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(inta_n) |-> ($past(ack) && $past(src) == 3'd5));

    p_inta_single_r10: assert property (@(posedge clk) disable iff (rst)
        !inta_n |=> inta_n);

    p_vec_source_r3: assert property (@(posedge clk) disable iff (rst)
        req_pend |-> ((vector != '0) != vec_ext));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .boundary (boundary),
    .ack      (ack),
    .req_pend (req_pend),
    .src      (src),
    .vector   (vector),
    .vec_ext  (vec_ext),
    .inta_n   (inta_n),
    .int_en   (int_en)
);

// File: tb/irq_prio_ctrl_test.sv
`timescale 1ns/1ps
module irq_prio_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b0;
    logic [4:0]  lines = '0;
    logic        en_stb = 1'b0, dis_stb = 1'b0, mask_wr = 1'b0;
    logic [2:0]  mask_in = '0;
    logic        boundary = 1'b0, ack = 1'b0;
    logic        req_pend, vec_ext, inta_n, int_en;
    logic [2:0]  src;
    logic [15:0] vector;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    irq_prio_ctrl uut (
        .clk(clk), .rst(rst),
        .irq_nmi(lines[0]), .irq_edge(lines[1]), .irq_lvl_a(lines[2]),
        .irq_lvl_b(lines[3]), .irq_gen(lines[4]),
        .en_stb(en_stb), .dis_stb(dis_stb), .mask_wr(mask_wr), .mask_in(mask_in),
        .boundary(boundary), .ack(ack),
        .req_pend(req_pend), .src(src), .vector(vector), .vec_ext(vec_ext),
        .inta_n(inta_n), .int_en(int_en)
    );

    // {lines gen,lb,la,edge,nmi}_{mask lb,la,edge}_{enable}_{expected code}
    localparam logic [11:0] TBL [0:11] = '{
        12'b11111_000_1_001, 12'b11110_000_1_010, 12'b11100_000_1_011,
        12'b11000_000_1_100, 12'b10000_000_1_101, 12'b11110_000_0_000,
        12'b00001_111_0_001, 12'b11110_001_1_011, 12'b11110_011_1_100,
        12'b11110_111_1_101, 12'b00000_000_1_000, 12'b00100_010_1_000
    };

    function automatic logic [15:0] exp_vec(logic [2:0] c);
        case (c)
            3'd1: return 16'h0024;
            3'd2: return 16'h003C;
            3'd3: return 16'h0034;
            3'd4: return 16'h002C;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; lines = '0; en_stb = 0; dis_stb = 0; mask_wr = 0;
        boundary = 0; ack = 0;
        tick();
        rst = 1'b0;
    endtask

    task automatic sample();
        boundary = 1'b1;
        tick();
        boundary = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        // R1 reset state
        mask_wr = 1; mask_in = 3'b111;
        tick();
        mask_wr = 0;
        do_reset();
        chk("R1 int_en", {15'd0, int_en}, 16'd0);
        chk("R1 req_pend", {15'd0, req_pend}, 16'd0);
        chk("R1 src", {13'd0, src}, 16'd0);
        chk("R1 vector", vector, 16'd0);
        chk("R1 inta_n", {15'd0, inta_n}, 16'd1);
        lines = 5'b00110; en_stb = 1;
        tick();
        en_stb = 0;
        sample();
        chk("R1 mask cleared, R11", {13'd0, src}, 16'd2);

        // R2 R3 R11 table walk
        for (int i = 0; i < 12; i++) begin
            logic [11:0] e;
            e = TBL[i];
            do_reset();
            mask_wr = 1; mask_in = e[6:4];
            en_stb = e[3]; dis_stb = !e[3];
            lines = e[11:7];
            tick();
            mask_wr = 0; en_stb = 0; dis_stb = 0;
            sample();
            chk("R2 table src", {13'd0, src}, {13'd0, e[2:0]});
            chk("R3 table vector", vector, exp_vec(e[2:0]));
            chk("R3 table vec_ext", {15'd0, vec_ext}, {15'd0, e[2:0] == 3'd5});
        end

        // R9 no sampling without boundary; R6 level withdrawal
        do_reset();
        en_stb = 1; lines = 5'b00100;
        tick();
        en_stb = 0;
        tick(); tick();
        chk("R9 no boundary", {13'd0, src}, 16'd0);
        sample();
        chk("R6 level sampled", {13'd0, src}, 16'd3);
        lines = '0;
        sample();
        chk("R6 level withdrawn", {13'd0, src}, 16'd0);

        // R5 edge latch survives the line falling, cleared on accept
        do_reset();
        en_stb = 1; lines = 5'b00010;
        tick();
        en_stb = 0; lines = '0;
        tick(); tick();
        sample();
        chk("R5 latched edge", {13'd0, src}, 16'd2);
        ack = 1;
        tick();
        ack = 0;
        chk("R8 pend cleared", {15'd0, req_pend}, 16'd0);
        chk("R8 enable cleared", {15'd0, int_en}, 16'd0);
        en_stb = 1;
        tick();
        en_stb = 0;
        sample();
        chk("R5 latch dropped", {13'd0, src}, 16'd0);

        // R8 maskable blocked after accept
        do_reset();
        en_stb = 1; lines = 5'b00100;
        tick();
        en_stb = 0;
        sample();
        ack = 1;
        tick();
        ack = 0;
        sample();
        chk("R8 blocked after accept", {13'd0, src}, 16'd0);

        // R4 non-maskable: no retrigger while held, dropped before sample
        do_reset();
        lines = 5'b00001;
        tick();
        sample();
        chk("R4 nmi without enable", {13'd0, src}, 16'd1);
        ack = 1;
        tick();
        ack = 0;
        sample();
        chk("R4 held high no retrigger", {13'd0, src}, 16'd0);
        lines = '0;
        tick();
        lines = 5'b00001;
        tick();
        lines = '0;
        sample();
        chk("R4 fell before sample", {13'd0, src}, 16'd0);

        // R10 general line acknowledge pulse
        do_reset();
        en_stb = 1; lines = 5'b10000;
        tick();
        en_stb = 0;
        sample();
        chk("R10 gen chosen", {13'd0, src}, 16'd5);
        chk("R10 inta idle", {15'd0, inta_n}, 16'd1);
        ack = 1;
        tick();
        ack = 0;
        chk("R10 inta low", {15'd0, inta_n}, 16'd0);
        tick();
        chk("R10 inta released", {15'd0, inta_n}, 16'd1);

        // R7 enable and disable strobes
        do_reset();
        en_stb = 1; dis_stb = 1;
        tick();
        chk("R7 both strobes", {15'd0, int_en}, 16'd0);
        dis_stb = 0;
        tick();
        chk("R7 enable", {15'd0, int_en}, 16'd1);
        en_stb = 0; dis_stb = 1;
        tick();
        dis_stb = 0;
        chk("R7 disable", {15'd0, int_en}, 16'd0);

        // R9 acknowledge with nothing pending is ignored
        en_stb = 1;
        tick();
        en_stb = 0; ack = 1;
        tick();
        ack = 0;
        chk("R9 idle ack enable", {15'd0, int_en}, 16'd1);
        chk("R9 idle ack inta", {15'd0, inta_n}, 16'd1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule